// File: doc/BRIEF.md
# Flag-Conditional Relative Branch Unit

This block executes two short conditional branches for a small 8-bit-style core. The core's program counter addresses bytes, and its instructions are 16-bit words. The unit holds the program counter. Each instruction cycle lasts four clocks, and a phase counter steps through them. In the first phase the unit latches the fetched word. In the second it extracts the 8-bit signed literal. In the third it samples the status flags and forms the branch target. In the fourth it writes the counter.

The two supported forms are "branch if zero flag clear" and "branch if overflow flag clear". Any other word is treated as an instruction handled elsewhere, and the counter simply advances by one word. A taken branch does three things: it jumps relative to the word that follows it, it raises a one-clock flush request so the fetch stage drops the word it already fetched, and it turns the next instruction cycle into a bubble. During the bubble nothing is executed and the counter holds, so the fetch stage can fetch the target. The unit never writes the status flags.

Top module: `flag_branch_unit`

## Requirements
- R1: While the synchronous active-high reset is asserted, and in the first clock after it, the counter is 0, the phase is Q1 (code 0), and both the flush request and the bubble indication are low.
- R2: A word whose bits [15:8] equal 8'hE1 is the branch-if-zero-clear form. A word whose bits [15:8] equal 8'hE5 is the branch-if-overflow-clear form. In both forms, bits [7:0] hold the signed offset n.
- R3: A taken branch at address A loads the counter with A + 2 + 2·n, with n as two's complement from -128 to +127. The sum wraps modulo 2^21, and bit 0 of the counter is always 0.
- R4: The 8'hE1 form is taken exactly when the zero flag is 0, whatever the overflow flag is. The 8'hE5 form is taken exactly when the overflow flag is 0, whatever the zero flag is.
- R5: A recognised branch that is not taken leaves the counter at A + 2 and raises no flush.
- R6: Any word with another upper byte advances the counter to A + 2 and raises no flush.
- R7: The phase output steps 0,1,2,3 (Q1 to Q4) and repeats. The counter changes only at the clock edge that ends Q4.
- R8: The flush request is high for exactly one clock, the Q4 clock of a taken branch, and at no other time.
- R9: The instruction cycle after a taken branch is a bubble. The bubble indication is high through all four of its phases, the word presented is ignored, the counter does not change, and no flush is raised.
- R10: The flags are sampled only in phase Q3. Their values in Q1, Q2 and Q4 have no effect on whether the branch is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock per phase |
| rst | input | 1 | Synchronous active-high reset |
| instrWord | input | 16 | Fetched instruction word, sampled at the end of Q1 |
| zeroFlag | input | 1 | Zero status flag, sampled at the end of Q3 |
| ovfFlag | input | 1 | Overflow status flag, sampled at the end of Q3 |
| pcOut | output | 21 | Program counter (byte address, even) |
| phaseOut | output | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| flushReq | output | 1 | One-clock request to discard the prefetched word; also the taken strobe |
| bubbleActive | output | 1 | High for the whole bubble cycle that follows a taken branch |

## Verification
The assertions check the following on every clock: the phase stepping, that the counter is frozen outside the Q4 write, that the counter stays even, that the flush pulse is confined to Q4 and followed by a bubble, and that the counter advances by exactly one word after a non-taken Q4 and holds through a bubble. The bench's scenarios are needed for the rest: the arithmetic value of the taken target for every offset, and its wrap below address zero. They also show the decode of the two opcodes against their neighbours and which flag each form tests. Finally, they show that flag values outside Q3 are ignored, by holding the opposite values in the other phases.

// File: rtl/brunit_pkg.sv
package brunit_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic latchWord;
    logic latchLiteral;
    logic computeTarget;
    logic writePc;
    logic selectTarget;
  } dpCtrl_t;

  // Branch forms: index 0 tests the zero flag, index 1 tests the overflow flag
  localparam int NUM_FORMS = 2;
  localparam logic [NUM_FORMS-1:0][7:0] FORM_OPC = {8'hE5, 8'hE1};

endpackage

// File: rtl/brunit_datapath.sv
module brunit_datapath
  import brunit_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int WORD_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  dpCtrl_t                 ctrl,
  input  logic [WORD_W-1:0]       instrWord,
  output logic [WORD_W-OFS_W-1:0] opcode,
  output logic [PC_W-1:0]         pcOut
);
  localparam int EXT_W = PC_W - OFS_W - 1;

  logic [WORD_W-1:0] instrReg;
  logic [OFS_W-1:0]  offsetReg;
  logic [PC_W-1:0]   targetReg;
  logic [PC_W-1:0]   pcReg;
  logic [PC_W-1:0]   byteOffset;
  logic [PC_W-1:0]   seqPc;

  // Sign-extend and double the word offset into a byte offset
  assign byteOffset = {{EXT_W{offsetReg[OFS_W-1]}}, offsetReg, 1'b0};
  assign seqPc      = pcReg + PC_W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      instrReg  <= '0;
      offsetReg <= '0;
      targetReg <= '0;
      pcReg     <= '0;
    end else begin
      if (ctrl.latchWord)     instrReg  <= instrWord;
      if (ctrl.latchLiteral)  offsetReg <= instrReg[OFS_W-1:0];
      if (ctrl.computeTarget) targetReg <= seqPc + byteOffset;
      if (ctrl.writePc)       pcReg     <= ctrl.selectTarget ? targetReg : seqPc;
    end
  end

  assign opcode = instrReg[WORD_W-1:OFS_W];
  assign pcOut  = pcReg;

endmodule

// File: rtl/brunit_ctrl.sv
module brunit_ctrl
  import brunit_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zeroFlag,
  input  logic             ovfFlag,
  output dpCtrl_t          ctrl,
  output logic [1:0]       phaseOut,
  output logic             flushReq,
  output logic             bubbleActive
);
  phase_e phase;
  logic   bubbleReg;
  logic   takenReg;
  logic [NUM_FORMS-1:0] flagVec;
  logic [NUM_FORMS-1:0] formHit;
  logic   condMet;

  assign flagVec = {ovfFlag, zeroFlag};

  for (genvar g = 0; g < NUM_FORMS; g++) begin : g_form
    assign formHit[g] = (opcode == FORM_OPC[g][OPC_W-1:0]) && !flagVec[g];
  end

  assign condMet = |formHit;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_Q1;
      bubbleReg <= 1'b0;
      takenReg  <= 1'b0;
    end else begin
      phase <= phase_e'(phase + 2'd1);
      case (phase)
        PH_Q3:   takenReg <= condMet && !bubbleReg;
        PH_Q4: begin
          bubbleReg <= takenReg && !bubbleReg;
          takenReg  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl.latchWord     = (phase == PH_Q1) && !bubbleReg;
    ctrl.latchLiteral  = (phase == PH_Q2) && !bubbleReg;
    ctrl.computeTarget = (phase == PH_Q3) && !bubbleReg;
    ctrl.writePc       = (phase == PH_Q4) && !bubbleReg;
    ctrl.selectTarget  = takenReg;
  end

  assign phaseOut     = phase;
  assign flushReq     = (phase == PH_Q4) && takenReg && !bubbleReg;
  assign bubbleActive = bubbleReg;

endmodule

// File: rtl/flag_branch_unit.sv
module flag_branch_unit
  import brunit_pkg::*;
#(
  parameter int PC_W   = 21,
  parameter int WORD_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instrWord,
  input  logic              zeroFlag,
  input  logic              ovfFlag,
  output logic [PC_W-1:0]   pcOut,
  output logic [1:0]        phaseOut,
  output logic              flushReq,
  output logic              bubbleActive
);
  localparam int OPC_W = WORD_W - OFS_W;

  dpCtrl_t          ctrl;
  logic [OPC_W-1:0] opcode;

  brunit_ctrl #(.OPC_W(OPC_W)) ctrl_i (
    .clk          (clk),
    .rst          (rst),
    .opcode       (opcode),
    .zeroFlag     (zeroFlag),
    .ovfFlag      (ovfFlag),
    .ctrl         (ctrl),
    .phaseOut     (phaseOut),
    .flushReq     (flushReq),
    .bubbleActive (bubbleActive)
  );

  brunit_datapath #(.PC_W(PC_W), .WORD_W(WORD_W), .OFS_W(OFS_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .instrWord (instrWord),
    .opcode    (opcode),
    .pcOut     (pcOut)
  );

endmodule

// File: rtl/brunit_checker.sv
module brunit_checker #(
  parameter int PC_W = 21
) (
  input logic            clk,
  input logic            rst,
  input logic [PC_W-1:0] pcOut,
  input logic [1:0]      phaseOut,
  input logic            flushReq,
  input logic            bubbleActive
);

  assert_phase_step_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phaseOut == $past(phaseOut) + 2'd1);

  assert_pc_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (phaseOut != 2'd0) |-> $stable(pcOut));

  assert_pc_even_R3: assert property (@(posedge clk) disable iff (rst)
    !pcOut[0]);

  assert_flush_in_q4_R8: assert property (@(posedge clk) disable iff (rst)
    flushReq |-> phaseOut == 2'd3);

  assert_flush_single_R8: assert property (@(posedge clk) disable iff (rst)
    flushReq |=> !flushReq);

  assert_flush_then_bubble_R9: assert property (@(posedge clk) disable iff (rst)
    flushReq |=> bubbleActive);

  assert_bubble_no_flush_R9: assert property (@(posedge clk) disable iff (rst)
    bubbleActive |-> !flushReq);

  assert_bubble_holds_pc_R9: assert property (@(posedge clk) disable iff (rst)
    (phaseOut == 2'd3 && bubbleActive) |=> $stable(pcOut));

  assert_seq_advance_R5: assert property (@(posedge clk) disable iff (rst)
    (phaseOut == 2'd3 && !bubbleActive && !flushReq) |=>
      pcOut == $past(pcOut) + PC_W'(2));

endmodule

bind flag_branch_unit brunit_checker #(.PC_W(PC_W)) chk_i (
  .clk          (clk),
  .rst          (rst),
  .pcOut        (pcOut),
  .phaseOut     (phaseOut),
  .flushReq     (flushReq),
  .bubbleActive (bubbleActive)
);

// File: tb/flag_branch_unit_tb_top.sv
module flag_branch_unit_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 21;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [15:0]     instrWord = '0;
  logic            zeroFlag = 1'b0;
  logic            ovfFlag = 1'b0;
  logic [PC_W-1:0] pcOut;
  logic [1:0]      phaseOut;
  logic            flushReq;
  logic            bubbleActive;

  int checks = 0;
  int failures = 0;
  logic [PC_W-1:0] expPc = '0;
  bit expBubble = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flag_branch_unit dut_i (
    .clk(clk), .rst(rst), .instrWord(instrWord), .zeroFlag(zeroFlag),
    .ovfFlag(ovfFlag), .pcOut(pcOut), .phaseOut(phaseOut),
    .flushReq(flushReq), .bubbleActive(bubbleActive)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One instruction cycle, starting at a negedge in phase Q1.
  // Flags hold the opposite values outside Q3 (R10).
  task automatic doCycle(input logic [15:0] w, input bit zQ3, input bit vQ3);
    logic [PC_W-1:0] ofs;
    bit taken;
    ofs   = {{(PC_W-9){w[7]}}, w[7:0], 1'b0};
    taken = !expBubble && ((w[15:8] == 8'hE1 && !zQ3) || (w[15:8] == 8'hE5 && !vQ3));
    instrWord = w; zeroFlag = !zQ3; ovfFlag = !vQ3;
    chk(phaseOut == 2'd0, "R7", "phase Q1", 32'(phaseOut), 0);
    chk(bubbleActive == expBubble, "R9", "bubble flag", 32'(bubbleActive), 32'(expBubble));
    @(negedge clk);
    chk(phaseOut == 2'd1 && pcOut == expPc, "R7", "phase Q2 pc held", 32'(pcOut), 32'(expPc));
    instrWord = ~w;
    @(negedge clk);
    zeroFlag = zQ3; ovfFlag = vQ3;
    @(negedge clk);
    zeroFlag = !zQ3; ovfFlag = !vQ3;
    chk(flushReq == taken, expBubble ? "R9" : "R8", "flush in Q4",
        32'(flushReq), 32'(taken));
    chk(pcOut == expPc, "R7", "pc before Q4 write", 32'(pcOut), 32'(expPc));
    @(negedge clk);
    if (expBubble) expPc = expPc;
    else if (taken) expPc = expPc + PC_W'(2) + ofs;
    else expPc = expPc + PC_W'(2);
    chk(pcOut == expPc,
        expBubble ? "R9" : (taken ? "R3" : ((w[15:8] == 8'hE1 || w[15:8] == 8'hE5) ? "R5" : "R6")),
        "pc after cycle", 32'(pcOut), 32'(expPc));
    expBubble = taken;
  endtask

  task automatic doReset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(pcOut == '0 && phaseOut == 2'd0 && !flushReq && !bubbleActive, "R1",
        "state in reset", {9'd0, pcOut, phaseOut}, 0);
    rst = 1'b0;
    expPc = '0; expBubble = 1'b0;
    chk(pcOut == '0 && phaseOut == 2'd0 && !flushReq && !bubbleActive, "R1",
        "state after reset", {9'd0, pcOut, phaseOut}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset();

    // R3 wrap below zero: 0 + 2 - 256
    doCycle(16'hE180, 1'b0, 1'b1);
    chk(pcOut == 21'h1FFF02, "R3", "wrap target", 32'(pcOut), 32'h1FFF02);
    doCycle(16'hE180, 1'b0, 1'b0); // R9 bubble ignores a branch word

    // R6 neighbours and other words
    doCycle(16'h0000, 1'b0, 1'b0);
    doCycle(16'hE4FF, 1'b0, 1'b0);
    doCycle(16'hE6FF, 1'b0, 1'b0);
    doCycle(16'hE010, 1'b0, 1'b0);
    doCycle(16'hE1FF & 16'hFEFF, 1'b0, 1'b0);
    doCycle(16'hA5E1, 1'b0, 1'b0);

    // R4 each form tests only its own flag
    doCycle(16'hE104, 1'b1, 1'b0);
    doCycle(16'hE504, 1'b0, 1'b1);
    doCycle(16'hE104, 1'b0, 1'b1);
    doCycle(16'h0000, 1'b0, 1'b0);
    doCycle(16'hE504, 1'b1, 1'b0);
    doCycle(16'h0000, 1'b0, 1'b0);

    // R2 R3 R4 R10 sweep of both forms, every offset, both flag values
    for (int op = 0; op < 2; op++) begin
      for (int n = 0; n < 256; n++) begin
        for (int f = 0; f < 2; f++) begin
          logic [15:0] w;
          bit own, other;
          w = {(op == 0) ? 8'hE1 : 8'hE5, 8'(n)};
          own = f[0]; other = n[0];
          if (op == 0) doCycle(w, own, other);
          else doCycle(w, other, own);
          if (expBubble) doCycle(16'h0000, 1'b0, 1'b0);
        end
      end
    end

    // Reset mid-run returns to the initial state
    doReset();
    doCycle(16'hE57F, 1'b1, 1'b0);
    chk(pcOut == 21'h100, "R3", "max forward offset", 32'(pcOut), 32'h100);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule